// File: doc/BRIEF.md
# ADC Conversion Chain Sequencer

This block takes over once an upstream arbiter has granted a trigger group. It captures that group's chain description and works through up to eight conversion segments in order. For each segment it sends a single-cycle request to the ADC, together with a channel number and a one-hot hold-register select. It then waits for the ADC's completion strobe and writes the returned sample into a result store indexed by group and segment.

Timing between events comes from a free-running prescaler. There is a programmable wait before the first segment. After each segment the sequencer either moves straight on to the next one or first waits a programmable interval. Segments can raise one of three per-group done flags when they finish. A trigger that hits the group already in progress raises that group's error flag.

Top module: `adc_chain_seq`

## Requirements
- R1: After reset `busy`, `adc_req` and every bit of `status` are 0.
- R2: The chain length input holds the segment count minus one (0 gives 1 segment, 7 gives 8). Exactly that many conversions are requested. `busy` falls on the edge that accepts the last `adc_ack`.
- R3: Each segment config is `SEG_W` = `CH_W`+6 bits. Segment i sits at `seg_cfg[i*SEG_W +: SEG_W]`, laid out as follows: bits [1:0] done code, bit 2 back-to-back, bits [5:3] one-hot hold select (1, 2 or 4), and bits above that the channel. Each request is a one-cycle `adc_req` pulse. `adc_chan` and `adc_hcsel` show that segment's fields and hold them until the ack.
- R4: With an initial delay of 0, the first `adc_req` rises on the edge that accepts the trigger. With a value D>0 and divider 0, it rises D cycles after that edge.
- R5: If a finishing segment has its back-to-back bit set, the next `adc_req` rises on the same edge that accepts its ack.
- R6: If the back-to-back bit is clear, the next request waits D interval ticks. An interval of 0 means no wait.
- R7: The prescaler yields one tick every `prediv`+1 cycles and runs free. A wait of D ticks therefore lasts between (D-1)*(prediv+1)+1 and D*(prediv+1) cycles.
- R8: Each ack stores `adc_data` at (active group, segment). `rd_data` returns the entry at (`rd_group`, `rd_seg`) one cycle after the address is applied.
- R9: Group g owns `status[g*4 +: 4]`. When a segment finishes, done code 1, 2 or 3 sets bit 0, 1 or 2 of its group's field. Code 0 sets nothing.
- R10: A trigger for the active group while `busy` is high sets bit 3 of that group's field. Any trigger that arrives while `busy` is high is dropped and starts no extra conversion.
- R11: A one in `status_clr` clears the matching status bit and leaves the other bits as they are. A set in the same cycle wins over the clear.
- R12: An `adc_ack` while no conversion is outstanding is ignored. No request, flag or busy change follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prediv | input | DIV_W | Prescaler divider, tick every prediv+1 cycles |
| trig_valid | input | 1 | Granted trigger strobe |
| trig_group | input | GRP_W | Group of the granted trigger |
| chain_len | input | LEN_W | Segment count minus one |
| init_dly | input | DLY_W | Ticks before the first segment |
| intv_dly | input | DLY_W | Ticks between segments when not back-to-back |
| seg_cfg | input | MAX_SEG*SEG_W | Packed segment descriptors |
| adc_req | output | 1 | One-cycle conversion request |
| adc_chan | output | CH_W | Channel for the current conversion |
| adc_hcsel | output | 3 | One-hot hold-register select |
| adc_ack | input | 1 | Conversion complete strobe |
| adc_data | input | RES_W | Conversion result, valid with adc_ack |
| busy | output | 1 | A chain is in progress |
| status | output | NUM_GRP*4 | Per-group done and error flags |
| status_clr | input | NUM_GRP*4 | Write-one-to-clear for status bits |
| rd_group | input | GRP_W | Result read group |
| rd_seg | input | LEN_W | Result read segment |
| rd_data | output | RES_W | Registered result read data |

## Verification
A wrong segment index or group register shows up at the ports at the next request. It appears as a wrong `adc_chan` or `adc_hcsel`, as a done flag landing in the wrong group field, or, one read cycle later, as a result stored under the wrong address. A broken delay counter moves the request edge by whole ticks, so measuring the distance in cycles from acceptance or from the last ack exposes it on the very request that follows. A sticking state machine shows up as `busy` failing to fall after the final ack, or as extra requests being counted.

// File: rtl/acs_pkg.sv
package acs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DLY  = 2'd1,
    ST_CONV = 2'd2
  } acs_state_e;

  localparam int FLAG_W  = 4;
  localparam int ERR_BIT = 3;
endpackage

// File: rtl/acs_prescaler.sv
module acs_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q >= div);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/acs_result_ram.sv
module acs_result_ram #(
  parameter int AW = 5,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/acs_flags.sv
module acs_flags #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/acs_ctrl.sv
module acs_ctrl
  import acs_pkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int MAX_SEG = 8,
  parameter int CH_W    = 5,
  parameter int DLY_W   = 10,
  localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int LEN_W  = (MAX_SEG > 1) ? $clog2(MAX_SEG) : 1,
  localparam int SEG_W  = CH_W + 6,
  localparam int CFG_W  = MAX_SEG * SEG_W,
  localparam int ST_W   = NUM_GRP * FLAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             trig_valid,
  input  logic [GRP_W-1:0] trig_group,
  input  logic [LEN_W-1:0] chain_len,
  input  logic [DLY_W-1:0] init_dly,
  input  logic [DLY_W-1:0] intv_dly,
  input  logic [CFG_W-1:0] seg_cfg,
  input  logic             adc_ack,
  output logic             adc_req,
  output logic [CH_W-1:0]  adc_chan,
  output logic [2:0]       adc_hcsel,
  output logic             busy,
  output logic             wr_en,
  output logic [GRP_W+LEN_W-1:0] wr_addr,
  output logic [ST_W-1:0]  set_vec
);
  acs_state_e       state_q;
  logic [GRP_W-1:0] grp_q;
  logic [LEN_W-1:0] seg_q, last_q, seg_nx;
  logic [CFG_W-1:0] cfg_q;
  logic [DLY_W-1:0] intv_q, tgt_q, dcnt_q;
  logic             req_q;
  logic [CH_W-1:0]  chan_q;
  logic [2:0]       hc_q;
  logic [SEG_W-1:0] cur_seg, nxt_seg, first_seg;
  logic             ack_take, dly_done;

  assign seg_nx    = seg_q + 1'b1;
  assign cur_seg   = cfg_q[int'(seg_q) * SEG_W +: SEG_W];
  assign nxt_seg   = cfg_q[int'(seg_nx) * SEG_W +: SEG_W];
  assign first_seg = seg_cfg[0 +: SEG_W];
  assign ack_take  = (state_q == ST_CONV) && adc_ack;
  assign dly_done  = ((DLY_W+1)'(dcnt_q) + (DLY_W+1)'(1)) >= (DLY_W+1)'(tgt_q);

  assign busy      = (state_q != ST_IDLE);
  assign adc_req   = req_q;
  assign adc_chan  = chan_q;
  assign adc_hcsel = hc_q;
  assign wr_en     = ack_take;
  assign wr_addr   = {grp_q, seg_q};

  always_comb begin
    set_vec = '0;
    if (ack_take && (cur_seg[1:0] != 2'd0))
      set_vec[int'(grp_q) * FLAG_W + int'(cur_seg[1:0]) - 1] = 1'b1;
    if (trig_valid && busy && (trig_group == grp_q))
      set_vec[int'(grp_q) * FLAG_W + ERR_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      grp_q   <= '0;
      seg_q   <= '0;
      last_q  <= '0;
      cfg_q   <= '0;
      intv_q  <= '0;
      tgt_q   <= '0;
      dcnt_q  <= '0;
      req_q   <= 1'b0;
      chan_q  <= '0;
      hc_q    <= '0;
    end else begin
      req_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (trig_valid) begin
            grp_q  <= trig_group;
            last_q <= chain_len;
            cfg_q  <= seg_cfg;
            intv_q <= intv_dly;
            seg_q  <= '0;
            dcnt_q <= '0;
            if (init_dly == '0) begin
              state_q <= ST_CONV;
              req_q   <= 1'b1;
              chan_q  <= first_seg[6 +: CH_W];
              hc_q    <= first_seg[5:3];
            end else begin
              state_q <= ST_DLY;
              tgt_q   <= init_dly;
            end
          end
        end
        ST_DLY: begin
          if (tick) begin
            if (dly_done) begin
              state_q <= ST_CONV;
              req_q   <= 1'b1;
              chan_q  <= cur_seg[6 +: CH_W];
              hc_q    <= cur_seg[5:3];
            end else begin
              dcnt_q <= dcnt_q + 1'b1;
            end
          end
        end
        ST_CONV: begin
          if (adc_ack) begin
            if (seg_q == last_q) begin
              state_q <= ST_IDLE;
            end else begin
              seg_q <= seg_nx;
              if (cur_seg[2] || (intv_q == '0)) begin
                req_q  <= 1'b1;
                chan_q <= nxt_seg[6 +: CH_W];
                hc_q   <= nxt_seg[5:3];
              end else begin
                state_q <= ST_DLY;
                tgt_q   <= intv_q;
                dcnt_q  <= '0;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_chain_seq.sv
module adc_chain_seq
  import acs_pkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int MAX_SEG = 8,
  parameter int CH_W    = 5,
  parameter int RES_W   = 12,
  parameter int DLY_W   = 10,
  parameter int DIV_W   = 8,
  localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int LEN_W  = (MAX_SEG > 1) ? $clog2(MAX_SEG) : 1,
  localparam int SEG_W  = CH_W + 6,
  localparam int CFG_W  = MAX_SEG * SEG_W,
  localparam int ST_W   = NUM_GRP * FLAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] prediv,
  input  logic             trig_valid,
  input  logic [GRP_W-1:0] trig_group,
  input  logic [LEN_W-1:0] chain_len,
  input  logic [DLY_W-1:0] init_dly,
  input  logic [DLY_W-1:0] intv_dly,
  input  logic [CFG_W-1:0] seg_cfg,
  output logic             adc_req,
  output logic [CH_W-1:0]  adc_chan,
  output logic [2:0]       adc_hcsel,
  input  logic             adc_ack,
  input  logic [RES_W-1:0] adc_data,
  output logic             busy,
  output logic [ST_W-1:0]  status,
  input  logic [ST_W-1:0]  status_clr,
  input  logic [GRP_W-1:0] rd_group,
  input  logic [LEN_W-1:0] rd_seg,
  output logic [RES_W-1:0] rd_data
);
  localparam int AW = GRP_W + LEN_W;

  logic          tick;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [ST_W-1:0] set_vec;

  acs_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .div(prediv), .tick(tick)
  );

  acs_ctrl #(
    .NUM_GRP(NUM_GRP), .MAX_SEG(MAX_SEG), .CH_W(CH_W), .DLY_W(DLY_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick),
    .trig_valid(trig_valid), .trig_group(trig_group), .chain_len(chain_len),
    .init_dly(init_dly), .intv_dly(intv_dly), .seg_cfg(seg_cfg),
    .adc_ack(adc_ack), .adc_req(adc_req), .adc_chan(adc_chan),
    .adc_hcsel(adc_hcsel), .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr),
    .set_vec(set_vec)
  );

  acs_result_ram #(.AW(AW), .DW(RES_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(adc_data),
    .raddr({rd_group, rd_seg}), .rdata(rd_data)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_flags
    acs_flags #(.W(FLAG_W)) u_flg (
      .clk(clk), .rst(rst),
      .set(set_vec[g*FLAG_W +: FLAG_W]),
      .clr(status_clr[g*FLAG_W +: FLAG_W]),
      .q(status[g*FLAG_W +: FLAG_W])
    );
  end
endmodule

// File: rtl/acs_checker.sv
module acs_checker #(
  parameter int NUM_GRP = 4,
  localparam int W = NUM_GRP * 4
) (
  input logic         clk,
  input logic         rst,
  input logic         trig_valid,
  input logic         adc_req,
  input logic         adc_ack,
  input logic         busy,
  input logic [W-1:0] status
);
  function automatic logic [W-1:0] done_mask();
    logic [W-1:0] m;
    m = '0;
    for (int g = 0; g < NUM_GRP; g++)
      for (int k = 0; k < 3; k++) m[g*4 + k] = 1'b1;
    return m;
  endfunction

  localparam logic [W-1:0] DMASK = done_mask();

  a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !adc_req && (status == '0)));

  a_r3_req_only_when_busy: assert property (@(posedge clk) disable iff (rst)
    adc_req |-> busy);

  a_r2_busy_ends_on_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(adc_ack));

  a_r9_done_needs_ack: assert property (@(posedge clk) disable iff (rst)
    (|(status & ~$past(status) & DMASK)) |-> $past(adc_ack));

  a_r10_err_needs_busy_trig: assert property (@(posedge clk) disable iff (rst)
    (|(status & ~$past(status) & ~DMASK)) |-> $past(trig_valid && busy));
endmodule

bind adc_chain_seq acs_checker #(.NUM_GRP(NUM_GRP)) u_chk (
  .clk(clk), .rst(rst), .trig_valid(trig_valid), .adc_req(adc_req),
  .adc_ack(adc_ack), .busy(busy), .status(status)
);

// File: tb/adc_chain_seq_tb.sv
module adc_chain_seq_tb;
  localparam int CH_W = 5, RES_W = 12, DLY_W = 10, DIV_W = 8;
  localparam int SEG_W = CH_W + 6, NSEG = 8, CFG_W = NSEG * SEG_W;

  logic clk = 0, rst = 1;
  logic [DIV_W-1:0] prediv = '0;
  logic trig_valid = 0;
  logic [1:0] trig_group = '0;
  logic [2:0] chain_len = '0;
  logic [DLY_W-1:0] init_dly = '0, intv_dly = '0;
  logic [CFG_W-1:0] seg_cfg = '0;
  logic adc_req, busy;
  logic [CH_W-1:0] adc_chan;
  logic [2:0] adc_hcsel;
  logic adc_ack = 0;
  logic [RES_W-1:0] adc_data = '0;
  logic [15:0] status, status_clr = '0;
  logic [1:0] rd_group = '0;
  logic [2:0] rd_seg = '0;
  logic [RES_W-1:0] rd_data;

  adc_chain_seq u_dut (.*);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  int lat = 2;
  logic stray = 0, fin = 0;
  int nreq = 0, nack = 0, pend = 0, wait_n = 0;
  int req_cyc [0:63];
  int req_chan [0:63];
  int req_hc [0:63];
  int ack_edge [0:63];
  int ack_dat [0:63];

  // ADC stub and request/ack log
  always @(negedge clk) begin
    adc_ack <= 1'b0;
    if (stray) begin
      adc_ack  <= 1'b1;
      adc_data <= 12'hABC;
    end else if (pend != 0) begin
      if (wait_n == 0) begin
        adc_ack        <= 1'b1;
        adc_data       <= {adc_chan, 7'(nack)};
        ack_edge[nack] <= cyc + 1;
        ack_dat[nack]  <= int'({adc_chan, 7'(nack)});
        nack           <= nack + 1;
        pend           <= 0;
      end else wait_n <= wait_n - 1;
    end
    if (adc_req) begin
      req_cyc[nreq]  <= cyc;
      req_chan[nreq] <= int'(adc_chan);
      req_hc[nreq]   <= int'(adc_hcsel);
      nreq           <= nreq + 1;
      pend           <= 1;
      wait_n         <= lat;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(string req, logic ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [SEG_W-1:0] seg(int ch, int hc, int b2b, int irq);
    return {CH_W'(ch), 3'(hc), 1'(b2b), 2'(irq)};
  endfunction

  task automatic fire(int grp, output int acc);
    step();
    trig_group = 2'(grp);
    trig_valid = 1;
    acc = cyc + 1;
    step();
    trig_valid = 0;
  endtask

  task automatic wait_idle();
    step();
    while (busy) step();
    step();
  endtask

  task automatic rd(int g, int s, output int v);
    step();
    rd_group = 2'(g);
    rd_seg = 3'(s);
    step();
    v = int'(rd_data);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy == 0, int'(busy), 0);
    chk("R1 req", adc_req == 0, int'(adc_req), 0);
    chk("R1 status", status == 0, int'(status), 0);
  endtask

  task automatic t_basic();
    int b, acc, v;
    b = nreq;
    lat = 2; prediv = 0; init_dly = 0; intv_dly = 5; chain_len = 2;
    seg_cfg = '0;
    seg_cfg[0*SEG_W +: SEG_W] = seg(3, 1, 1, 0);
    seg_cfg[1*SEG_W +: SEG_W] = seg(9, 2, 1, 2);
    seg_cfg[2*SEG_W +: SEG_W] = seg(17, 4, 1, 1);
    fire(1, acc);
    wait_idle();
    chk("R2 count len=2", nreq - b == 3, nreq - b, 3);
    chk("R4 init 0 immediate", req_cyc[b] == acc, req_cyc[b], acc);
    chk("R3 chan seg0", req_chan[b] == 3, req_chan[b], 3);
    chk("R3 chan seg1", req_chan[b+1] == 9, req_chan[b+1], 9);
    chk("R3 chan seg2", req_chan[b+2] == 17, req_chan[b+2], 17);
    chk("R3 hcsel seg1", req_hc[b+1] == 2, req_hc[b+1], 2);
    chk("R3 hcsel seg2", req_hc[b+2] == 4, req_hc[b+2], 4);
    chk("R5 b2b gap", req_cyc[b+1] == ack_edge[b], req_cyc[b+1], ack_edge[b]);
    chk("R9 group1 flags", status[7:4] == 4'b0011, int'(status[7:4]), 3);
    chk("R9 other groups clear", {status[15:8], status[3:0]} == 0,
        int'({status[15:8], status[3:0]}), 0);
    chk("R2 busy low", busy == 0, int'(busy), 0);
    for (int s = 0; s < 3; s++) begin
      rd(1, s, v);
      chk("R8 result", v == ack_dat[b+s], v, ack_dat[b+s]);
    end
  endtask

  task automatic t_delays();
    int b, acc;
    b = nreq;
    lat = 1; prediv = 0; init_dly = 3; intv_dly = 4; chain_len = 1;
    seg_cfg = '0;
    seg_cfg[0*SEG_W +: SEG_W] = seg(5, 1, 0, 0);
    seg_cfg[1*SEG_W +: SEG_W] = seg(6, 2, 0, 0);
    fire(2, acc);
    wait_idle();
    chk("R4 init delay 3", req_cyc[b] == acc + 3, req_cyc[b], acc + 3);
    chk("R6 interval 4", req_cyc[b+1] == ack_edge[b] + 4, req_cyc[b+1], ack_edge[b] + 4);
    b = nreq;
    init_dly = 0; intv_dly = 0;
    fire(2, acc);
    wait_idle();
    chk("R6 interval 0", req_cyc[b+1] == ack_edge[b], req_cyc[b+1], ack_edge[b]);
  endtask

  task automatic t_presc();
    int b, acc, d0, d1;
    b = nreq;
    lat = 1; prediv = 3; init_dly = 2; intv_dly = 1; chain_len = 1;
    seg_cfg = '0;
    seg_cfg[0*SEG_W +: SEG_W] = seg(7, 1, 0, 0);
    seg_cfg[1*SEG_W +: SEG_W] = seg(8, 1, 0, 0);
    fire(0, acc);
    wait_idle();
    d0 = req_cyc[b] - acc;
    d1 = req_cyc[b+1] - ack_edge[b];
    chk("R7 init 2 ticks div 3", d0 >= 5 && d0 <= 8, d0, 8);
    chk("R7 interval 1 tick div 3", d1 >= 1 && d1 <= 4, d1, 4);
    prediv = 0;
  endtask

  task automatic t_len8();
    int b, acc;
    b = nreq;
    lat = 0; init_dly = 0; chain_len = 7;
    seg_cfg = '0;
    for (int s = 0; s < 8; s++)
      seg_cfg[s*SEG_W +: SEG_W] = seg(s + 10, 1 << (s % 3), 1, (s == 7) ? 3 : 0);
    fire(3, acc);
    wait_idle();
    chk("R2 count len=7", nreq - b == 8, nreq - b, 8);
    chk("R3 chan seg7", req_chan[b+7] == 17, req_chan[b+7], 17);
    chk("R9 group3 DONE2", status[15:12] == 4'b0100, int'(status[15:12]), 4);
  endtask

  task automatic t_busy_trig();
    int b, acc, a2;
    step();
    status_clr = 16'h000F;
    step();
    status_clr = '0;
    b = nreq;
    lat = 20; init_dly = 0; chain_len = 0;
    seg_cfg = '0;
    seg_cfg[0 +: SEG_W] = seg(2, 1, 1, 0);
    fire(0, acc);
    step(); step();
    fire(0, a2);
    fire(3, a2);
    wait_idle();
    chk("R10 dropped triggers", nreq - b == 1, nreq - b, 1);
    chk("R10 error group0", status[3] == 1, int'(status[3]), 1);
    chk("R10 no error group3", status[15] == 0, int'(status[15]), 0);
    step();
    status_clr = 16'h0008;
    step();
    status_clr = '0;
    step();
    chk("R11 clear error", status[3] == 0, int'(status[3]), 0);
    chk("R11 others kept", status[15:12] == 4'b0100, int'(status[15:12]), 4);
    lat = 2;
  endtask

  task automatic t_stray();
    int b, st, v;
    b = nreq;
    st = int'(status);
    step();
    stray = 1;
    step();
    stray = 0;
    step(); step();
    chk("R12 no request", nreq == b, nreq, b);
    chk("R12 busy stays low", busy == 0, int'(busy), 0);
    chk("R12 status unchanged", int'(status) == st, int'(status), st);
    rd(1, 0, v);
    chk("R12 result unchanged", v == ack_dat[0], v, ack_dat[0]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    step();
    t_reset();
    t_basic();
    t_delays();
    t_presc();
    t_len8();
    t_busy_trig();
    t_stray();
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule